// File: doc/BRIEF.md
# GPIO Controller with Interrupt Sensing

This block manages a bank of general-purpose pins behind a small word-addressed register port. Each pin works in one of three ways: as a general input, as a general output whose data and drive enable are sent to the pad, or as an interrupt input. An interrupt input can sense a high level, a low level, a rising edge or a falling edge. The pin is inverted first when its polarity bit asks for it, and then the level or edge is detected.

Pin levels pass through a two-stage synchronizer before anything reads them. Level-sensitive pins show their adjusted level as pending. Edge-sensitive pins latch a pending flag that stays set until software writes a one to the acknowledge register. A per-pin enable is lowered through one register and raised through another. The single interrupt output is active when any pin in interrupt mode is both pending and unmasked. Software services the pins by reading the pending word and acknowledging the lowest set bit until the word reads zero.

The block has no state machine. The register selector is an enumerated type decoded with unique case, and the state is held in flat per-pin registers.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every pin is a general input with the mode, direction, output data, polarity and trigger registers at zero, and every pin is masked (the mask register reads zero).
- R2: pin_oe bit i is 1 exactly when mode bit i is 0 (general mode) and direction bit i is 1 (output). A mode bit of 1 selects interrupt input and forces the drive enable off.
- R3: The output-data register (offset 0x08) reads back what was last written to it, and pin_out always presents its value.
- R4: The input-data register (offset 0x0C) returns pin_in as it was two clock edges earlier.
- R5: A polarity bit of 1 (offset 0x20) inverts the sensed pin, so the pin senses a falling edge or a low level. A polarity bit of 0 senses a rising edge or a high level.
- R6: When the trigger bit is 0 (level mode, offset 0x24), the pending bit equals the polarity-adjusted synchronized level. An acknowledge write has no lasting effect while that level is asserted.
- R7: When the trigger bit is 1 (edge mode), a detected edge sets the pending bit. The bit stays set until a 1 is written to the same bit of the acknowledge register (offset 0x14). Bits written as 0 there leave their pending bits unchanged.
- R8: If an edge is detected in the same cycle that its acknowledge is written, the pending bit ends up set.
- R9: Writing 0 to a bit of the mask register (offset 0x18) masks that pin, and a 1 there has no effect. Writing 1 to a bit at offset 0x1C unmasks that pin. The mask register reads 1 for unmasked pins. irq is the OR over all pins of pending AND unmasked AND mode bit.
- R10: Registers sit at byte offsets 0x00 mode, 0x04 direction, 0x08 output data, 0x0C input data, 0x10 pending, 0x14 acknowledge, 0x18 mask, 0x1C unmask, 0x20 polarity and 0x24 trigger. A read of the acknowledge or unmask offset returns zero, and so does a read of any other address or any read while bus_we is high.
- R11: Several pending bits can be set at once. Acknowledging the lowest set bit on each pass empties the register in ascending pin order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | NPIN | Write data |
| bus_rdata | output | NPIN | Read data, valid in the same cycle as the read |
| pin_in | input | NPIN | Raw pin levels from the pads |
| pin_out | output | NPIN | Output data sent to the pads |
| pin_oe | output | NPIN | Per-pin drive enable sent to the pads |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is an edge and its acknowledge landing on the same clock edge. An edge is seen three edges after the pin moves, so the bench changes the pin and then lines the acknowledge write up to meet that third edge. The case where several pins are pending at once needs each pin's edge latched before any of them is acknowledged. The bench therefore raises three edge pins together and then runs a lowest-first service loop. After each acknowledge it reads the pending word back. A behavioural model advances on every clock and is compared on every falling edge against all outputs.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned OFF_MODE   = 32'h00;
    localparam int unsigned OFF_DIR    = 32'h04;
    localparam int unsigned OFF_DOUT   = 32'h08;
    localparam int unsigned OFF_DIN    = 32'h0C;
    localparam int unsigned OFF_PEND   = 32'h10;
    localparam int unsigned OFF_ACK    = 32'h14;
    localparam int unsigned OFF_MASK   = 32'h18;
    localparam int unsigned OFF_UNMASK = 32'h1C;
    localparam int unsigned OFF_POL    = 32'h20;
    localparam int unsigned OFF_TRIG   = 32'h24;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_DIR,
        SEL_DOUT,
        SEL_DIN,
        SEL_PEND,
        SEL_ACK,
        SEL_MASK,
        SEL_UNMASK,
        SEL_POL,
        SEL_TRIG
    } reg_sel_e;

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;

    // R4: second stage follows the first one clock later
    p_sync_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stage2_q == $past(stage1_q)));

endmodule

// File: rtl/gpio_sense.sv
module gpio_sense #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] edge_i,
    input  logic [W-1:0] ack_i,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] sensed;
    logic [W-1:0] prev_q;
    logic [W-1:0] latch_q;
    logic [W-1:0] hit;

    assign sensed = lvl_i ^ pol_i;
    assign hit    = sensed & ~prev_q & edge_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            latch_q <= '0;
        end else begin
            prev_q  <= sensed;
            latch_q <= ((latch_q & ~ack_i) | hit) & edge_i;
        end
    end

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_pin
            assign pend_o[g] = edge_i[g] ? latch_q[g] : sensed[g];
        end
    endgenerate

    // R7: a latched flag with no acknowledge survives while the pin stays in edge mode
    p_edge_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(latch_q) & ~$past(ack_i) & $past(edge_i) & edge_i & ~latch_q) == '0));

    // R8: a detected edge always leaves the flag set, whatever the acknowledge
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(hit) & edge_i & ~pend_o) == '0));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPIN   = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic              irq
);
    localparam logic [NPIN-1:0] ZERO = '0;

    reg_sel_e        sel;
    logic            wr;
    logic [NPIN-1:0] mode_q, dir_q, dout_q, pol_q, trig_q, en_q;
    logic [NPIN-1:0] din, pend, ack;

    always_comb begin
        sel = SEL_NONE;
        if      (bus_addr == ADDR_W'(OFF_MODE))   sel = SEL_MODE;
        else if (bus_addr == ADDR_W'(OFF_DIR))    sel = SEL_DIR;
        else if (bus_addr == ADDR_W'(OFF_DOUT))   sel = SEL_DOUT;
        else if (bus_addr == ADDR_W'(OFF_DIN))    sel = SEL_DIN;
        else if (bus_addr == ADDR_W'(OFF_PEND))   sel = SEL_PEND;
        else if (bus_addr == ADDR_W'(OFF_ACK))    sel = SEL_ACK;
        else if (bus_addr == ADDR_W'(OFF_MASK))   sel = SEL_MASK;
        else if (bus_addr == ADDR_W'(OFF_UNMASK)) sel = SEL_UNMASK;
        else if (bus_addr == ADDR_W'(OFF_POL))    sel = SEL_POL;
        else if (bus_addr == ADDR_W'(OFF_TRIG))   sel = SEL_TRIG;
    end

    assign wr  = bus_en & bus_we;
    assign ack = (wr && sel == SEL_ACK) ? bus_wdata : ZERO;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            dir_q  <= '0;
            dout_q <= '0;
            pol_q  <= '0;
            trig_q <= '0;
            en_q   <= '0;
        end else if (wr) begin
            unique case (sel)
                SEL_MODE:   mode_q <= bus_wdata;
                SEL_DIR:    dir_q  <= bus_wdata;
                SEL_DOUT:   dout_q <= bus_wdata;
                SEL_POL:    pol_q  <= bus_wdata;
                SEL_TRIG:   trig_q <= bus_wdata;
                SEL_MASK:   en_q   <= en_q & bus_wdata;
                SEL_UNMASK: en_q   <= en_q | bus_wdata;
                default:    ;
            endcase
        end
    end

    gpio_sync2 #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_in),
        .q_o   (din)
    );

    gpio_sense #(.W(NPIN)) u_sense (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (din),
        .pol_i  (pol_q),
        .edge_i (trig_q),
        .ack_i  (ack),
        .pend_o (pend)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            unique case (sel)
                SEL_MODE: bus_rdata = mode_q;
                SEL_DIR:  bus_rdata = dir_q;
                SEL_DOUT: bus_rdata = dout_q;
                SEL_DIN:  bus_rdata = din;
                SEL_PEND: bus_rdata = pend;
                SEL_MASK: bus_rdata = en_q;
                SEL_POL:  bus_rdata = pol_q;
                SEL_TRIG: bus_rdata = trig_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign pin_out = dout_q;
    assign pin_oe  = ~mode_q & dir_q;
    assign irq     = |(pend & en_q & mode_q);

    // R9: a zero written to the mask register leaves that pin masked
    p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_MASK) |=> ((en_q & ~$past(bus_wdata)) == '0));

    // R9: a one written to the unmask register leaves that pin enabled
    p_unmask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_UNMASK) |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)));

    // R9: the request needs at least one unmasked pin in interrupt mode
    p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|(en_q & mode_q)));

    // R3: output data holds without a write
    p_dout_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(dout_q));

endmodule

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, pin_out, pin_oe;
    logic [31:0] pin_in = '0;
    logic        irq;

    int    vectors = 0, miscompares = 0;
    bit    cmp_en = 1'b0, done = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    bit [31:0] m_s1, m_s2, m_prev, m_latch, m_mode, m_dir, m_dout, m_pol, m_trig, m_en;

    gpio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit [31:0] m_pend();
        bit [31:0] r;
        for (int i = 0; i < 32; i++)
            r[i] = m_trig[i] ? m_latch[i] : (m_s2[i] ^ m_pol[i]);
        return r;
    endfunction

    function automatic bit [31:0] m_read();
        if (!bus_en || bus_we) return 0;
        case (bus_addr)
            6'h00: return m_mode;
            6'h04: return m_dir;
            6'h08: return m_dout;
            6'h0C: return m_s2;
            6'h10: return m_pend();
            6'h18: return m_en;
            6'h20: return m_pol;
            6'h24: return m_trig;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_s1, m_s2, m_prev, m_latch, m_mode, m_dir, m_dout, m_pol, m_trig, m_en} = '0;
        end else begin
            bit [31:0] sensed, ackw, nxt;
            sensed = m_s2 ^ m_pol;
            ackw   = (bus_en && bus_we && bus_addr == 6'h14) ? bus_wdata : 0;
            for (int i = 0; i < 32; i++) begin
                if (!m_trig[i])                       nxt[i] = 1'b0;
                else if (sensed[i] && !m_prev[i])     nxt[i] = 1'b1;
                else if (ackw[i])                     nxt[i] = 1'b0;
                else                                  nxt[i] = m_latch[i];
            end
            m_latch = nxt;
            m_prev  = sensed;
            m_s2    = m_s1;
            m_s1    = pin_in;
            if (bus_en && bus_we) begin
                case (bus_addr)
                    6'h00: m_mode = bus_wdata;
                    6'h04: m_dir  = bus_wdata;
                    6'h08: m_dout = bus_wdata;
                    6'h18: m_en   = m_en & bus_wdata;
                    6'h1C: m_en   = m_en | bus_wdata;
                    6'h20: m_pol  = bus_wdata;
                    6'h24: m_trig = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            bit any;
            any = |(m_pend() & m_en & m_mode);
            chk("R2 pin_oe", pin_oe, ~m_mode & m_dir);
            chk("R3 pin_out", pin_out, m_dout);
            chk("R9 irq", {31'd0, irq}, {31'd0, any});
            chk({cur_req, " rdata"}, bus_rdata, m_read());
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        bus_en = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic expect_rd(input logic [5:0] a, input logic [31:0] e, input string tag);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, e);
    endtask

    task automatic expect_irq(input logic e, input string tag);
        @(negedge clk);
        chk(tag, {31'd0, irq}, {31'd0, e});
    endtask

    task automatic setpin(input logic [31:0] v);
        @(posedge clk); #1;
        pin_in = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        miscompares++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int order[$];
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cmp_en = 1'b1;

        cur_req = "R1";
        expect_rd(6'h00, 0, "R1 mode");
        expect_rd(6'h04, 0, "R1 dir");
        expect_rd(6'h08, 0, "R1 dout");
        expect_rd(6'h18, 0, "R1 mask");
        expect_rd(6'h20, 0, "R1 pol");
        expect_rd(6'h24, 0, "R1 trig");

        cur_req = "R10";
        expect_rd(6'h2C, 0, "R10 unmapped");
        expect_rd(6'h14, 0, "R10 ack reads zero");
        expect_rd(6'h1C, 0, "R10 unmask reads zero");

        cur_req = "R3";
        wr(6'h08, 32'hA5A5_0F0F);
        expect_rd(6'h08, 32'hA5A5_0F0F, "R3 dout readback");
        chk("R3 pin_out", pin_out, 32'hA5A5_0F0F);

        cur_req = "R2";
        wr(6'h04, 32'h0000_FFFF);
        wr(6'h00, 32'h0000_00FF);
        @(negedge clk);
        chk("R2 oe gated by mode", pin_oe, 32'h0000_FF00);

        cur_req = "R4";
        setpin(32'h1234_5678);
        idle(3);
        expect_rd(6'h0C, 32'h1234_5678, "R4 din");
        setpin(0);
        idle(3);

        cur_req = "R6";
        wr(6'h1C, 32'h10);
        setpin(32'h10);
        idle(4);
        expect_irq(1'b1, "R6 level irq");
        wr(6'h14, 32'h10);
        expect_rd(6'h10, 32'h10, "R6 ack no lasting effect");
        setpin(0);
        idle(4);
        expect_irq(1'b0, "R6 level released");

        cur_req = "R5";
        wr(6'h20, 32'h20);
        wr(6'h24, 32'h20);
        idle(2);
        wr(6'h14, 32'h20);
        setpin(32'h20);
        idle(4);
        expect_rd(6'h10, 0, "R5 rising ignored when inverted");
        setpin(0);
        idle(4);
        expect_rd(6'h10, 32'h20, "R5 falling edge latched");
        wr(6'h14, 32'h20);

        cur_req = "R7";
        wr(6'h24, 32'h120);
        idle(2);
        setpin(32'h100);
        idle(4);
        setpin(0);
        idle(4);
        expect_rd(6'h10, 32'h100, "R7 edge held");
        wr(6'h14, 32'h0);
        expect_rd(6'h10, 32'h100, "R7 zero ack ignored");
        wr(6'h14, 32'h100);
        expect_rd(6'h10, 0, "R7 ack clears");

        cur_req = "R8";
        wr(6'h24, 32'h320);
        idle(2);
        setpin(32'h200);
        @(posedge clk);
        wr(6'h14, 32'h200);
        expect_rd(6'h10, 32'h200, "R8 set beats ack");

        cur_req = "R9";
        wr(6'h00, 32'h3FF);
        wr(6'h1C, 32'h200);
        expect_irq(1'b1, "R9 unmasked irq");
        wr(6'h18, 32'hFFFF_FFFF);
        expect_irq(1'b1, "R9 mask ones no effect");
        wr(6'h18, ~32'h200);
        expect_irq(1'b0, "R9 masked");
        expect_rd(6'h18, 32'h10, "R9 mask readback");
        wr(6'h1C, 32'h200);
        wr(6'h00, 32'h1FF);
        expect_irq(1'b0, "R9 mode gates irq");
        wr(6'h14, 32'h200);

        cur_req = "R11";
        wr(6'h00, 32'h0010_03FF);
        wr(6'h24, 32'h0010_03A8);
        idle(2);
        setpin(32'h0010_0288);
        idle(5);
        expect_rd(6'h10, 32'h0010_0088, "R11 three pending");
        for (int pass = 0; pass < 8; pass++) begin
            int low;
            rd(6'h10, v);
            if (v == 0) break;
            low = -1;
            for (int b = 31; b >= 0; b--) if (v[b]) low = b;
            order.push_back(low);
            wr(6'h14, 32'h1 << low);
        end
        chk("R11 passes", order.size(), 3);
        if (order.size() == 3) begin
            chk("R11 first", order[0], 3);
            chk("R11 second", order[1], 7);
            chk("R11 third", order[2], 20);
        end
        expect_rd(6'h10, 0, "R11 emptied");

        idle(2);
        finish_run();
    end
endmodule